// File: doc/BRIEF.md
# I/O Window Address Translator

This block sits between a processor-side access port and a legacy I/O bus. The processor sees the legacy port space through an 8 MB window that starts at processor address 0x80000000. Each access carries a byte address, a size (byte, half-word or word), a direction and write data. When the address falls inside the window, the block turns the window offset into a 16-bit legacy port address and forwards the access in the same cycle. Size, direction and data pass through unchanged.

A map-mode input, taken from bit 0 of a map-type control register elsewhere in the system, chooses one of two translations. In the contiguous map the port is simply the low 16 bits of the offset. In the sparse map every group of 32 ports gets its own 4 KB page. The offset's five lowest bits select the port within a group, and offset bits 22:12 become port bits 15:5. The handshake is a single-cycle request/acknowledge. The legacy side's acknowledge and read data travel back to the processor combinationally, and an access outside the window is never answered.

Top module: `io_win_xlat`

## Requirements
- R1: An access is forwarded (ioReq high) only while cpuReq is high, reset is released and cpuAddr lies in 0x80000000..0x807FFFFF. When nothing is forwarded, ioPort, ioSize, ioWrite and ioWdata are all zero.
- R2: With mapMode 0 (contiguous), ioPort equals window offset bits 15:0, where the offset is cpuAddr minus 0x80000000.
- R3: With mapMode 1 (sparse), ioPort bits 4:0 equal offset bits 4:0 and ioPort bits 15:5 equal offset bits 22:12.
- R4: With mapMode 1, offset bits 11:5 have no effect on ioPort.
- R5: With mapMode 0, offset bits 22:16 have no effect on ioPort.
- R6: A forwarded access carries cpuSize (0 byte, 1 half-word, 2 word), cpuWrite and cpuWdata unchanged on ioSize, ioWrite and ioWdata. The port translation is the same for every size.
- R7: cpuAck equals ioAck while an access is forwarded and is low otherwise, including for out-of-window addresses with ioAck high.
- R8: cpuRdata equals ioRdata while cpuAck is high and is zero otherwise.
- R9: While rstN is low, ioReq and cpuAck stay low whatever the inputs.
- R10: Translation and acknowledge have zero latency: outputs follow inputs within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used by the embedded checks |
| rstN | input | 1 | Active-low reset; blocks forwarding while low |
| mapMode | input | 1 | 0 contiguous map, 1 sparse map |
| cpuReq | input | 1 | Processor access request |
| cpuAddr | input | 32 | Processor byte address |
| cpuSize | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| cpuWrite | input | 1 | 1 write, 0 read |
| cpuWdata | input | 32 | Processor write data |
| cpuAck | output | 1 | Acknowledge returned to the processor |
| cpuRdata | output | 32 | Read data returned to the processor |
| ioReq | output | 1 | Forwarded request on the legacy bus |
| ioPort | output | 16 | Legacy port address |
| ioSize | output | 2 | Forwarded access size |
| ioWrite | output | 1 | Forwarded direction |
| ioWdata | output | 32 | Forwarded write data |
| ioAck | input | 1 | Legacy bus acknowledge |
| ioRdata | input | 32 | Legacy bus read data |

## Verification
The block holds no state, so any fault shows at the ports in the same cycle as the stimulus that exposes it. A bad window decode shows up as a stray ioReq or a missing one, or as an acknowledge leaking back for an out-of-window address. A bad bit splice shows up as a wrong ioPort for offsets whose bits 22:12 or 4:0 differ, or as a port that moves when the ignored middle bits change. Random offsets in both map modes find the splice faults. Directed addresses at the window edges and at the neighbours just outside it find the decode faults.

// File: rtl/io_win_pkg.sv
package io_win_pkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic fwd;     // access is inside the window and forwarded
    logic ack;     // legacy acknowledge may be returned
    logic sparse;  // sparse page map selected
  } winStrobeT;
endpackage

// File: rtl/io_win_ctrl.sv
module io_win_ctrl
  import io_win_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WIN_LOG2 = 23,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000
) (
  input  logic                       rstN,
  input  logic                       mapMode,
  input  logic                       cpuReq,
  input  logic [ADDR_W-1:WIN_LOG2]   cpuAddrHi,
  input  logic                       ioAck,
  output winStrobeT                  strb
);
  localparam logic [ADDR_W-WIN_LOG2-1:0] BASE_HI = WIN_BASE[ADDR_W-1:WIN_LOG2];

  logic winHit;

  always_comb begin
    winHit      = (cpuAddrHi == BASE_HI);
    strb.fwd    = rstN & cpuReq & winHit;
    strb.ack    = strb.fwd & ioAck;
    strb.sparse = mapMode;
  end
endmodule

// File: rtl/io_win_path.sv
module io_win_path
  import io_win_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PORT_W = 16,
  parameter int WIN_LOG2 = 23,
  parameter int PAGE_LOG2 = 12,
  parameter int GROUP_LOG2 = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  winStrobeT            strb,
  input  logic [WIN_LOG2-1:0]  offset,
  input  logic [1:0]           cpuSize,
  input  logic                 cpuWrite,
  input  logic [DATA_W-1:0]    cpuWdata,
  input  logic [DATA_W-1:0]    ioRdata,
  output logic [PORT_W-1:0]    ioPort,
  output logic [1:0]           ioSize,
  output logic                 ioWrite,
  output logic [DATA_W-1:0]    ioWdata,
  output logic [DATA_W-1:0]    cpuRdata
);
  localparam int PAGE_BITS = WIN_LOG2 - PAGE_LOG2;
  localparam int SPARSE_W  = PAGE_BITS + GROUP_LOG2;

  logic [SPARSE_W-1:0] sparseRaw;
  logic [PORT_W-1:0]   sparsePort;
  logic [PORT_W-1:0]   contigPort;

  assign sparseRaw  = {offset[WIN_LOG2-1:PAGE_LOG2], offset[GROUP_LOG2-1:0]};
  assign contigPort = offset[PORT_W-1:0];

  // Fit the spliced sparse index to the port width.
  generate
    if (SPARSE_W >= PORT_W) begin : gTrunc
      assign sparsePort = sparseRaw[PORT_W-1:0];
    end else begin : gPad
      assign sparsePort = {{(PORT_W-SPARSE_W){1'b0}}, sparseRaw};
    end
  endgenerate

  always_comb begin
    ioPort   = '0;
    ioSize   = '0;
    ioWrite  = 1'b0;
    ioWdata  = '0;
    if (strb.fwd) begin
      ioPort  = strb.sparse ? sparsePort : contigPort;
      ioSize  = cpuSize;
      ioWrite = cpuWrite;
      ioWdata = cpuWdata;
    end
    cpuRdata = strb.ack ? ioRdata : '0;
  end

  // R6: forwarded fields match the processor side
  a_r6_fields_pass: assert property (@(posedge clk) disable iff (!rstN)
    strb.fwd |-> (ioSize == cpuSize && ioWrite == cpuWrite && ioWdata == cpuWdata));
  // R3: sparse map keeps the in-group port bits
  a_r3_sparse_low: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fwd && strb.sparse) |-> ioPort[GROUP_LOG2-1:0] == offset[GROUP_LOG2-1:0]);
  // R2: contiguous map keeps the low offset bits
  a_r2_contig_low: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fwd && !strb.sparse) |-> ioPort == offset[PORT_W-1:0]);
endmodule

// File: rtl/io_win_xlat.sv
module io_win_xlat
  import io_win_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PORT_W = 16,
  parameter int WIN_LOG2 = 23,
  parameter int PAGE_LOG2 = 12,
  parameter int GROUP_LOG2 = 5,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mapMode,
  input  logic              cpuReq,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [1:0]        cpuSize,
  input  logic              cpuWrite,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuAck,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              ioReq,
  output logic [PORT_W-1:0] ioPort,
  output logic [1:0]        ioSize,
  output logic              ioWrite,
  output logic [DATA_W-1:0] ioWdata,
  input  logic              ioAck,
  input  logic [DATA_W-1:0] ioRdata
);
  winStrobeT strb;

  io_win_ctrl #(
    .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .WIN_BASE(WIN_BASE)
  ) uCtrl (
    .rstN(rstN), .mapMode(mapMode), .cpuReq(cpuReq),
    .cpuAddrHi(cpuAddr[ADDR_W-1:WIN_LOG2]), .ioAck(ioAck), .strb(strb)
  );

  io_win_path #(
    .DATA_W(DATA_W), .PORT_W(PORT_W), .WIN_LOG2(WIN_LOG2),
    .PAGE_LOG2(PAGE_LOG2), .GROUP_LOG2(GROUP_LOG2)
  ) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .offset(cpuAddr[WIN_LOG2-1:0]),
    .cpuSize(cpuSize), .cpuWrite(cpuWrite), .cpuWdata(cpuWdata),
    .ioRdata(ioRdata), .ioPort(ioPort), .ioSize(ioSize), .ioWrite(ioWrite),
    .ioWdata(ioWdata), .cpuRdata(cpuRdata)
  );

  assign ioReq  = strb.fwd;
  assign cpuAck = strb.ack;

  // R1: nothing outside the window reaches the legacy bus
  a_r1_outside_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[ADDR_W-1:WIN_LOG2] != WIN_BASE[ADDR_W-1:WIN_LOG2]) |-> !ioReq);
  // R7: an acknowledge needs a forwarded access and a legacy acknowledge
  a_r7_ack_needs_fwd: assert property (@(posedge clk) disable iff (!rstN)
    cpuAck |-> (ioReq && ioAck && cpuReq));
  // R8: read data is quiet without an acknowledge
  a_r8_rdata_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cpuAck |-> (cpuRdata == '0));
  // R9: reset blocks both directions
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (!ioReq && !cpuAck));
endmodule

// File: tb/sim_io_win_xlat.sv
module sim_io_win_xlat;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mapMode = 1'b0;
  logic cpuReq = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic [1:0] cpuSize = '0;
  logic cpuWrite = 1'b0;
  logic [31:0] cpuWdata = '0;
  logic cpuAck;
  logic [31:0] cpuRdata;
  logic ioReq;
  logic [15:0] ioPort;
  logic [1:0] ioSize;
  logic ioWrite;
  logic [31:0] ioWdata;
  logic ioAck = 1'b0;
  logic [31:0] ioRdata = '0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  io_win_xlat u0 (
    .clk(clk), .rstN(rstN), .mapMode(mapMode), .cpuReq(cpuReq),
    .cpuAddr(cpuAddr), .cpuSize(cpuSize), .cpuWrite(cpuWrite),
    .cpuWdata(cpuWdata), .cpuAck(cpuAck), .cpuRdata(cpuRdata),
    .ioReq(ioReq), .ioPort(ioPort), .ioSize(ioSize), .ioWrite(ioWrite),
    .ioWdata(ioWdata), .ioAck(ioAck), .ioRdata(ioRdata)
  );

  function automatic logic inWin(input logic [31:0] a);
    return a >= 32'h8000_0000 && a <= 32'h807F_FFFF;
  endfunction

  function automatic logic [15:0] expPort(input logic m, input logic [31:0] a);
    logic [31:0] off;
    off = a - 32'h8000_0000;
    if (m) return {off[22:12], off[4:0]};
    return off[15:0];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive on the falling edge, then sample once the logic has settled.
  task automatic drive(input logic rq, input logic m, input logic [31:0] a,
                       input logic [1:0] sz, input logic wr, input logic [31:0] wd,
                       input logic ak, input logic [31:0] rd);
    @(negedge clk);
    cpuReq = rq; mapMode = m; cpuAddr = a; cpuSize = sz;
    cpuWrite = wr; cpuWdata = wd; ioAck = ak; ioRdata = rd;
    #1;
  endtask

  // Full comparison of every output against the requirements.
  task automatic fullChk(input string tag);
    logic f;
    f = rstN && cpuReq && inWin(cpuAddr);
    chk({tag, " R1 ioReq"}, 64'(ioReq), 64'(f));
    chk({tag, " R2/R3 ioPort"}, 64'(ioPort), f ? 64'(expPort(mapMode, cpuAddr)) : 64'd0);
    chk({tag, " R6 ioSize"}, 64'(ioSize), f ? 64'(cpuSize) : 64'd0);
    chk({tag, " R6 ioWrite"}, 64'(ioWrite), f ? 64'(cpuWrite) : 64'd0);
    chk({tag, " R6 ioWdata"}, 64'(ioWdata), f ? 64'(cpuWdata) : 64'd0);
    chk({tag, " R7 cpuAck"}, 64'(cpuAck), 64'(f && ioAck));
    chk({tag, " R8 cpuRdata"}, 64'(cpuRdata), (f && ioAck) ? 64'(ioRdata) : 64'd0);
  endtask

  initial begin
    logic [15:0] p0;
    void'($urandom(32'd4242));
    // R9: reset holds everything off even with an in-window access
    drive(1, 1, 32'h8000_1234, 2, 1, 32'hDEAD_BEEF, 1, 32'h1111_2222);
    chk("R9 reset ioReq", 64'(ioReq), 64'd0);
    chk("R9 reset cpuAck", 64'(cpuAck), 64'd0);
    chk("R9 reset cpuRdata", 64'(cpuRdata), 64'd0);
    @(negedge clk); rstN = 1'b1;

    // R10: same-cycle response once reset is released
    drive(1, 0, 32'h8000_03F8, 0, 0, 32'h0, 1, 32'h0000_00A5);
    chk("R10 ioReq same cycle", 64'(ioReq), 64'd1);
    chk("R2 contig port", 64'(ioPort), 64'h03F8);
    chk("R8 rdata back", 64'(cpuRdata), 64'hA5);

    // R1: window edges and neighbours outside it
    drive(1, 0, 32'h7FFF_FFFF, 2, 1, 32'h5555, 1, 32'h77); fullChk("below");
    chk("R7 no ack outside", 64'(cpuAck), 64'd0);
    drive(1, 0, 32'h8080_0000, 2, 1, 32'h5555, 1, 32'h77); fullChk("above");
    chk("R1 no fwd above", 64'(ioReq), 64'd0);
    drive(1, 1, 32'h807F_FFFF, 1, 0, 32'h0, 1, 32'h99); fullChk("top edge");
    chk("R3 sparse top edge", 64'(ioPort), 64'hFFFF);
    drive(1, 1, 32'h8000_0000, 0, 0, 32'h0, 0, 32'h99); fullChk("bottom edge");
    drive(0, 0, 32'h8000_0010, 2, 1, 32'h1234, 1, 32'h99); fullChk("idle");
    chk("R1 idle no fwd", 64'(ioReq), 64'd0);

    // R3: sparse splice, page 3 group port 0x13
    drive(1, 1, 32'h8000_3013, 0, 1, 32'hAB, 0, 0);
    chk("R3 sparse splice", 64'(ioPort), 64'h0073);

    // R4: sparse ignores offset bits 11:5
    drive(1, 1, 32'h8012_3000 | 32'h0000_0007, 0, 0, 0, 0, 0);
    p0 = ioPort;
    drive(1, 1, 32'h8012_3FE7, 0, 0, 0, 0, 0);
    chk("R4 sparse middle ignored", 64'(ioPort), 64'(p0));

    // R5: contiguous ignores offset bits 22:16
    drive(1, 0, 32'h8000_ABCD, 1, 0, 0, 0, 0);
    p0 = ioPort;
    drive(1, 0, 32'h807F_ABCD, 1, 0, 0, 0, 0);
    chk("R5 contig high ignored", 64'(ioPort), 64'(p0));

    // R6: every size gives the same port
    for (int s = 0; s < 3; s++) begin
      drive(1, 1, 32'h8045_6789, 2'(s), 1, 32'hC0DE_0000 + s, 1, 0);
      chk("R6 size same port", 64'(ioPort), 64'(expPort(1'b1, 32'h8045_6789)));
      chk("R6 size forwarded", 64'(ioSize), 64'(s));
    end

    // Random mix: mostly in-window addresses
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      a = $urandom();
      if ($urandom_range(0, 3) != 0) a = 32'h8000_0000 | (a & 32'h007F_FFFF);
      drive(1'($urandom_range(0, 4) != 0), 1'($urandom()), a,
            2'($urandom_range(0, 2)), 1'($urandom()), $urandom(),
            1'($urandom()), $urandom());
      fullChk("random");
    end

    // R9: reset again in the middle of traffic
    @(negedge clk); rstN = 1'b0;
    drive(1, 0, 32'h8000_0092, 0, 1, 32'h1, 1, 32'h3);
    chk("R9 mid reset ioReq", 64'(ioReq), 64'd0);
    chk("R9 mid reset cpuAck", 64'(cpuAck), 64'd0);
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule